// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a handheld console's cartridge bus (16-bit address, 8-bit data, separate read and write strobes) and a large external ROM plus a battery-backed RAM. Bus writes that land in the lower 32 KiB do not reach memory. They are decoded as updates to a small set of control registers: a RAM unlock byte, the switchable ROM page, the RAM page and a banking-mode bit. Bus reads and writes are translated into physical ROM and RAM addresses, and each access produces a single-cycle strobe toward the external memories.

A two-bit controller-kind input picks one of three banking variants, or a plain unbanked cartridge. The input is captured only while reset is held. The variants differ in three ways: how wide the ROM page register is, whether page zero is remapped, and how a shared register is routed between the upper ROM page bits and the RAM page.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A bus write is acted on only in the cycle where `bus_wr` is sampled low after being sampled high. The byte used is `bus_wdata` as sampled in the previous cycle, while the strobe was still high. The resulting `ram_we` pulse appears one cycle later and lasts one cycle.
- R2: A bus read starts on a sampled rising edge of `bus_rd`. `rom_rd` or `ram_rd` pulses for one cycle in the next cycle. The returned byte is loaded into `bus_rdata` on the following edge and held until the next serviced read. If a write edge and a read edge fall in the same cycle, the write wins and the read is dropped.
- R3: Only addresses 0x0000–0x7FFF (ROM window) and 0xA000–0xBFFF (RAM window) are serviced. Accesses elsewhere produce no strobe, change no register and leave `bus_rdata` unchanged.
- R4: Writes to 0x0000–0x1FFF load the 8-bit unlock register. A RAM-window write reaches the RAM (`ram_we`) only while that register equals 0x0A. RAM reads are not gated by it.
- R5: Kind 0: a write to 0x2000–0x3FFF sets page bits 4:0 from data bits 4:0 and keeps bits 6:5. A zero in data bits 4:0 selects 1 instead.
- R6: Kind 1: a write to 0x2000–0x3FFF sets the page to data bits 6:0, with upper bits cleared. Zero selects 1.
- R7: Kind 2: a write to 0x2000–0x2FFF sets page bits 7:0 from the data. A write to 0x3000–0x3FFF sets page bit 8 from data bit 0. Page zero stays zero.
- R8: A write to 0x4000–0x5FFF, for kind 0 with mode bit 0, sets page bits 6:5 from data bits 1:0. In every other case it loads the RAM page (low 4 bits kept).
- R9: A write to 0x6000–0x7FFF loads the mode bit from data bit 0. For kind 0 with mode 0, RAM accesses always use RAM page 0.
- R10: A read of 0x0000–0x3FFF drives `rom_addr` = addr[13:0] (page 0). A read of 0x4000–0x7FFF drives `rom_addr` = page × 0x4000 + (addr − 0x4000).
- R11: A RAM access drives `ram_addr` = RAM page × 0x2000 + (addr − 0xA000).
- R12: Reset sets ROM page 1, RAM page 0, unlock 0 and mode 0, with all strobes low and `bus_rdata` 0. `ctl_kind` is sampled only during reset. Kind 3 is a plain cartridge: register writes are ignored, 0x4000–0x7FFF always maps to page 1, and the RAM window behaves as unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; `ctl_kind` is captured while low |
| ctl_kind | input | 2 | Banking variant: 0, 1, 2 banked kinds, 3 plain |
| bus_addr | input | 16 | Cartridge bus address |
| bus_wdata | input | 8 | Cartridge bus write data |
| bus_wr | input | 1 | Write strobe, acted on at its falling edge |
| bus_rd | input | 1 | Read strobe, acted on at its rising edge |
| bus_rdata | output | 8 | Registered read data, held between reads |
| rom_addr | output | 23 | Physical ROM byte address |
| rom_rd | output | 1 | One-cycle ROM read strobe |
| rom_rdata | input | 8 | ROM data, valid while `rom_rd` is high |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_rd | output | 1 | One-cycle RAM read strobe |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data, valid while `ram_rd` is high |

## Verification
The bench targets four kinds of fault:
- **Page-zero remap.** Page zero is written on every kind. A design that remaps it for the 9-bit variant, or fails to remap it for the other two, reads the wrong 16 KiB page.
- **Shared register in the 0x4000 window.** This is exercised in both mode settings. A misrouted register either corrupts the ROM page or lets RAM page bits leak into mode-0 RAM addresses.
- **Write data and unlock byte.** The bench changes the write data in the cycle the strobe falls. A design that uses the current byte instead of the captured one writes the wrong value. Unlock bytes near 0x0A must block RAM writes.
- **Unmapped accesses and kind capture.** Reads and writes outside the two windows must leave the held read data untouched. The kind input is changed after reset, and the behaviour must not follow it.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    K_LO5   = 2'd0,
    K_LO7   = 2'd1,
    K_SPLIT = 2'd2,
    K_PLAIN = 2'd3
  } cbc_kind_e;

  localparam int CBC_UNLOCK = 8'h0A;
endpackage

// File: rtl/cbc_edge.sv
module cbc_edge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic          wr_fall,
  output logic          rd_rise,
  output logic [DW-1:0] wdata_q
);
  logic wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_q    <= wr;
      rd_q    <= rd;
      wdata_q <= wdata;
    end
  end

  assign wr_fall = wr_q & ~wr;
  assign rd_rise = ~rd_q & rd;
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BANK_W  = 9,
  parameter int RBANK_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cbc_kind_e          kind,
  input  logic               wr_fall,
  input  logic [3:0]         addr_top,
  input  logic [DW-1:0]      wdata_q,
  output logic [BANK_W-1:0]  rom_bank,
  output logic [RBANK_W-1:0] ram_bank,
  output logic [DW-1:0]      unlock,
  output logic               mode
);
  localparam int LO5 = 5;
  localparam int LO7 = 7;

  logic reg_hit;
  assign reg_hit = wr_fall && !addr_top[3] && (kind != K_PLAIN);

  function automatic logic [LO5-1:0] nz5(input logic [LO5-1:0] v);
    return (v == '0) ? LO5'(1) : v;
  endfunction

  function automatic logic [LO7-1:0] nz7(input logic [LO7-1:0] v);
    return (v == '0) ? LO7'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank <= BANK_W'(1);
      ram_bank <= '0;
      unlock   <= '0;
      mode     <= 1'b0;
    end else if (reg_hit) begin
      case (addr_top[2:1])
        2'd0: unlock <= wdata_q;
        2'd1: begin
          case (kind)
            K_LO5:   rom_bank[LO5-1:0] <= nz5(wdata_q[LO5-1:0]);
            K_LO7:   rom_bank <= {{(BANK_W-LO7){1'b0}}, nz7(wdata_q[LO7-1:0])};
            K_SPLIT: begin
              if (!addr_top[0]) rom_bank[7:0] <= wdata_q;
              else              rom_bank[8]   <= wdata_q[0];
            end
            default: ;
          endcase
        end
        2'd2: begin
          if (kind == K_LO5 && !mode) rom_bank[6:5] <= wdata_q[1:0];
          else                        ram_bank <= wdata_q[RBANK_W-1:0];
        end
        default: mode <= wdata_q[0];
      endcase
    end
  end
endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
  import cbc_pkg::*;
#(
  parameter int ROM_AW  = 23,
  parameter int RAM_AW  = 17,
  parameter int ROM_PW  = 14,
  parameter int RAM_PW  = 13,
  localparam int BANK_W  = ROM_AW - ROM_PW,
  localparam int RBANK_W = RAM_AW - RAM_PW
) (
  input  cbc_kind_e          kind,
  input  logic               mode,
  input  logic [BANK_W-1:0]  rom_bank,
  input  logic [RBANK_W-1:0] ram_bank,
  input  logic [15:0]        addr,
  output logic               rom_hit,
  output logic               ram_hit,
  output logic [ROM_AW-1:0]  rom_pa,
  output logic [RAM_AW-1:0]  ram_pa
);
  function automatic logic [ROM_AW-1:0] rom_map(input logic hi, input logic [BANK_W-1:0] bk,
                                                input logic [ROM_PW-1:0] off);
    return {(hi ? bk : BANK_W'(0)), off};
  endfunction

  function automatic logic [RAM_AW-1:0] ram_map(input logic pin0, input logic [RBANK_W-1:0] bk,
                                                input logic [RAM_PW-1:0] off);
    return {(pin0 ? RBANK_W'(0) : bk), off};
  endfunction

  assign rom_hit = !addr[15];
  assign ram_hit = (addr[15:13] == 3'b101) && (kind != K_PLAIN);
  assign rom_pa  = rom_map(addr[14], rom_bank, addr[ROM_PW-1:0]);
  assign ram_pa  = ram_map(kind == K_LO5 && !mode, ram_bank, addr[RAM_PW-1:0]);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ROM_AW = 23,
  parameter int RAM_AW = 17,
  parameter int ROM_PW = 14,
  parameter int RAM_PW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_kind,
  input  logic [15:0]       bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  input  logic [DW-1:0]     rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_we,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata
);
  localparam int BANK_W  = ROM_AW - ROM_PW;
  localparam int RBANK_W = RAM_AW - RAM_PW;

  cbc_kind_e           kind_q;
  logic                wr_fall, rd_rise;
  logic [DW-1:0]       wdata_q;
  logic [BANK_W-1:0]   rom_bank;
  logic [RBANK_W-1:0]  ram_bank;
  logic [DW-1:0]       unlock;
  logic                mode;
  logic                rom_hit, ram_hit, ram_open;
  logic [ROM_AW-1:0]   rom_pa;
  logic [RAM_AW-1:0]   ram_pa;

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= cbc_kind_e'(ctl_kind);
  end

  cbc_edge #(.DW(DW)) u_edge (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .wr_fall(wr_fall), .rd_rise(rd_rise), .wdata_q(wdata_q)
  );

  cbc_regs #(.DW(DW), .BANK_W(BANK_W), .RBANK_W(RBANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .kind(kind_q), .wr_fall(wr_fall),
    .addr_top(bus_addr[15:12]), .wdata_q(wdata_q),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .unlock(unlock), .mode(mode)
  );

  cbc_xlate #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .ROM_PW(ROM_PW), .RAM_PW(RAM_PW)) u_xlate (
    .kind(kind_q), .mode(mode), .rom_bank(rom_bank), .ram_bank(ram_bank), .addr(bus_addr),
    .rom_hit(rom_hit), .ram_hit(ram_hit), .rom_pa(rom_pa), .ram_pa(ram_pa)
  );

  assign ram_open = (unlock == DW'(CBC_UNLOCK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_rd    <= 1'b0;
      ram_rd    <= 1'b0;
      ram_we    <= 1'b0;
      rom_addr  <= '0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      bus_rdata <= '0;
    end else begin
      rom_rd <= 1'b0;
      ram_rd <= 1'b0;
      ram_we <= 1'b0;
      if (wr_fall) begin
        if (ram_hit && ram_open) begin
          ram_we    <= 1'b1;
          ram_addr  <= ram_pa;
          ram_wdata <= wdata_q;
        end
      end else if (rd_rise) begin
        if (rom_hit) begin
          rom_rd   <= 1'b1;
          rom_addr <= rom_pa;
        end else if (ram_hit) begin
          ram_rd   <= 1'b1;
          ram_addr <= ram_pa;
        end
      end
      if (rom_rd)      bus_rdata <= rom_rdata;
      else if (ram_rd) bus_rdata <= ram_rdata;
    end
  end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ROM_AW = 23,
  parameter int RAM_AW = 17,
  parameter int ROM_PW = 14,
  localparam int BANK_W = ROM_AW - ROM_PW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [15:0]       bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              rom_rd,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_rd,
  input logic              ram_we,
  input logic [DW-1:0]     ram_wdata,
  input logic              ram_open,
  input cbc_kind_e         kind_q,
  input logic [BANK_W-1:0] rom_bank
);
  // R1: RAM write only after a high-then-low strobe, with the earlier byte
  p_wr_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(bus_wr, 2) && !$past(bus_wr) && ram_wdata == $past(bus_wdata, 2)));

  p_rd_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd || ram_rd) |-> ($past(bus_rd) && !$past(bus_rd, 2)));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rom_rd) && !$past(ram_rd)) |-> $stable(bus_rdata));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd, ram_rd, ram_we}));

  p_rom_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> !$past(bus_addr[15]));

  p_ram_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_we) |-> ($past(bus_addr[15:13]) == 3'b101));

  p_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(ram_open));

  p_page_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_LO5) |-> (rom_bank[4:0] != 5'd0));

  p_page_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_LO7) |-> (rom_bank[6:0] != 7'd0 && rom_bank[BANK_W-1:7] == '0));

  p_low_page0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && $past(bus_addr[15:14]) == 2'b00) |-> (rom_addr[ROM_AW-1:ROM_PW] == '0));

  p_kind_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(kind_q));

  p_plain_noram_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_PLAIN) |-> (!ram_rd && !ram_we && rom_bank == BANK_W'(1)));
endmodule

bind cart_bank_ctrl cbc_checker #(.DW(DW), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .ROM_PW(ROM_PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_rd(rom_rd), .rom_addr(rom_addr),
  .ram_rd(ram_rd), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_open(ram_open),
  .kind_q(kind_q), .rom_bank(rom_bank)
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl_kind = 2'd0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata, rom_rdata, ram_rdata, ram_wdata;
  logic [22:0] rom_addr;
  logic [16:0] ram_addr;
  logic        rom_rd, ram_rd, ram_we;

  logic [7:0] phys_ram [0:131071];
  logic [7:0] exp_ram  [0:131071];

  int n_cmp = 0, n_bad = 0;
  int kk, m_bank, m_rbank, m_en, m_mode;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  cart_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctl_kind(ctl_kind), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_byte(input logic [22:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], 1'b1};
  endfunction

  assign rom_rdata = rom_byte(rom_addr);
  assign ram_rdata = phys_ram[ram_addr];

  always @(posedge clk) if (ram_we) phys_ram[ram_addr] <= ram_wdata;

  function automatic int exp_rom(input int a);
    if (a < 'h4000) return a;
    return m_bank * 16384 + (a - 16384);
  endfunction

  function automatic int exp_ramad(input int a);
    int bk;
    bk = (kk == 0 && m_mode == 0) ? 0 : (m_rbank % 16);
    return bk * 8192 + (a - 'hA000);
  endfunction

  function automatic bit in_ram(input int a);
    return a >= 'hA000 && a < 'hC000 && kk != 3;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic model_write(input int a, input int d);
    int lo;
    if (kk == 3 || a >= 'h8000) return;
    if (a < 'h2000) m_en = d;
    else if (a < 'h4000) begin
      case (kk)
        0: begin lo = d % 32;  if (lo == 0) lo = 1; m_bank = (m_bank / 32) * 32 + lo; end
        1: begin lo = d % 128; if (lo == 0) lo = 1; m_bank = lo; end
        default: begin
          if (a < 'h3000) m_bank = (m_bank / 256) * 256 + d;
          else            m_bank = (m_bank % 256) + (d % 2) * 256;
        end
      endcase
    end else if (a < 'h6000) begin
      if (kk == 0 && m_mode == 0) m_bank = (m_bank % 32) + (d % 4) * 32;
      else m_rbank = d;
    end else m_mode = d % 2;
  endtask

  task automatic do_reset(input int k);
    @(negedge clk);
    rst_n = 1'b0; ctl_kind = 2'(k); bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ctl_kind = 2'(~k);
    kk = k; m_bank = 1; m_rbank = 0; m_en = 0; m_mode = 0;
    chk("R12 strobes after reset", {29'd0, rom_rd, ram_rd, ram_we}, 0);
    chk("R12 rdata after reset", bus_rdata, 0);
  endtask

  task automatic do_write(input int a, input int d, input string req);
    int pa;
    bit hit;
    @(negedge clk);
    bus_addr = 16'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'(~d);
    @(negedge clk);
    hit = in_ram(a) && m_en == 'h0A;
    pa = exp_ramad(a);
    chk({req, " R1/R4 ram_we"}, ram_we, hit);
    if (hit) begin
      chk({req, " R11 ram_addr"}, ram_addr, pa);
      chk({req, " R1 ram_wdata"}, ram_wdata, d);
      exp_ram[pa] = 8'(d);
    end
    model_write(a, d);
  endtask

  task automatic do_read(input int a, input string req);
    int prev, pa, ed;
    @(negedge clk);
    prev = bus_rdata;
    bus_addr = 16'(a); bus_rd = 1'b1;
    @(negedge clk);
    if (a < 'h8000) begin
      pa = exp_rom(a);
      chk({req, " R2 rom_rd"}, {ram_rd, rom_rd}, 1);
      chk({req, " R10 rom_addr"}, rom_addr, pa);
      ed = rom_byte(23'(pa));
    end else if (in_ram(a)) begin
      pa = exp_ramad(a);
      chk({req, " R2 ram_rd"}, {rom_rd, ram_rd}, 1);
      chk({req, " R11 ram_addr"}, ram_addr, pa);
      ed = exp_ram[pa];
    end else begin
      chk({req, " R3 no strobe"}, {rom_rd, ram_rd}, 0);
      ed = prev;
    end
    @(negedge clk);
    chk({req, " R2 bus_rdata"}, bus_rdata, ed);
    bus_rd = 1'b0;
  endtask

  function automatic int pick_addr();
    int r;
    r = $urandom % 8;
    if (r < 4) return $urandom % 'h8000;
    if (r < 7) return 'hA000 + $urandom % 'h2000;
    return (r == 7 && ($urandom % 2)) ? 'h8000 + $urandom % 'h2000 : 'hC000 + $urandom % 'h4000;
  endfunction

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int a, d;
      a = pick_addr();
      d = $urandom % 256;
      if (a < 'h2000 && ($urandom % 2)) d = 'h0A;
      if ($urandom % 2) do_write(a, d, "rand");
      else do_read(a, "rand");
    end
  endtask

  initial begin
    for (int i = 0; i < 131072; i++) begin phys_ram[i] = 8'hFF; exp_ram[i] = 8'hFF; end
    void'($urandom(32'h00C0FFEE));

    // kind 0
    do_reset(0);
    do_read('h4123, "R12 reset page 1");
    do_write('h2000, 'h00, "R5 zero");
    do_read('h4001, "R5 zero->1");
    do_write('h2100, 'hFF, "R5 mask");
    do_write('h4000, 'h03, "R8 mode0 high bits");
    do_read('h7FFF, "R8 page 0x7F");
    do_write('h2000, 'h20, "R5 keep high");
    do_read('h4000, "R5 high kept");
    do_read('h1234, "R10 low window");
    do_write('h0000, 'h0A, "R4 unlock");
    do_write('hA010, 'h5C, "R9 mode0 ram write");
    do_write('h6000, 'h01, "R9 mode1");
    do_write('h4000, 'h06, "R8 ram page");
    do_write('hB000, 'h77, "R11 paged write");
    do_read('hA010, "R11 page6 empty");
    do_write('h6000, 'h00, "R9 back mode0");
    do_read('hA010, "R9 page0 read");
    do_write('h1000, 'h0B, "R4 lock");
    do_write('hA010, 'h99, "R4 blocked write");
    do_read('hA010, "R4 value kept");
    do_write('h9000, 'h05, "R3 ignored write");
    do_read('hC000, "R3 ignored read");
    do_read('h4000, "R3 page unchanged");
    random_run(250);

    // kind 1
    do_reset(1);
    do_write('h2000, 'h00, "R6 zero");
    do_read('h5000, "R6 zero->1");
    do_write('h3FFF, 'hFF, "R6 mask");
    do_read('h4000, "R6 page 0x7F");
    do_write('h0000, 'h0A, "R4 unlock");
    do_write('h4000, 'h03, "R8 ram page");
    do_write('hA001, 'h42, "R11 write");
    do_read('hA001, "R11 read");
    random_run(250);

    // kind 2
    do_reset(2);
    do_write('h2000, 'h00, "R7 zero stays");
    do_read('h4abc, "R7 page 0");
    do_write('h3000, 'h01, "R7 bit8");
    do_read('h4abc, "R7 page 0x100");
    do_write('h2FFF, 'hA5, "R7 low byte");
    do_read('h7000, "R7 page 0x1A5");
    random_run(250);

    // kind 3
    do_reset(3);
    do_write('h2000, 'h05, "R12 plain ignores");
    do_write('h0000, 'h0A, "R12 plain unlock ignored");
    do_read('h4000, "R12 plain page 1");
    do_write('hA000, 'h11, "R12 plain ram write");
    do_read('hA000, "R12 plain ram read");
    random_run(150);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule